// File: doc/BRIEF.md
# Configurable Output Logic Cell

This block is the output stage that sits behind one sum-of-products OR term in a programmable logic array. It holds one rising-edge D flip-flop and two selectors, set by a four-bit configuration word. The word decides whether the pin carries the registered or the combinatorial sum, whether the pin is active-high or active-low, and which of three signals goes back into the array as feedback.

The flip-flop has a synchronous preset and an asynchronous clear, both supplied as global product terms. Clear takes priority over preset. A separate product term enables the pin driver. When that term is false the pin is released, and the feedback path can then return whatever an external source drives onto the pin. The configuration word has sixteen codes, and they map onto twelve distinct behaviours because two feedback codes both select the pin.

Top module: `logic_out_cell`

## Requirements
- R1: With cfg[3]=1 (registered), the pin data is the flip-flop Q, which loads sum_in at each rising clock edge when neither preset nor clear is active.
- R2: With cfg[3]=0 (combinatorial), the pin data follows sum_in in the same cycle with no register in the path.
- R3: When preset_term is high and clear_term is low at a rising clock edge, Q becomes 1 after that edge.
- R4: When clear_term is high, Q is 0 at once, without waiting for a clock edge, and stays 0 while clear_term remains high.
- R5: When preset_term and clear_term are both high, Q is 0.
- R6: cfg[2]=0 drives the selected data onto pin_out unchanged (active-high). cfg[2]=1 drives its complement (active-low).
- R7: pin_oe equals oe_term. While oe_term is low, pin_out is held at 0.
- R8: Feedback code cfg[1:0]=0 returns the true Q of the flip-flop, independent of cfg[2].
- R9: Feedback code cfg[1:0]=1 returns sum_in.
- R10: Feedback codes cfg[1:0]=2 and 3 return the pin level. That level is pin_out while the driver is enabled and pin_in while it is released.
- R11: While rst_n is low, Q is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flip-flop |
| sum_in | input | 1 | OR-term result from the array |
| preset_term | input | 1 | Global synchronous preset term |
| clear_term | input | 1 | Global asynchronous clear term |
| oe_term | input | 1 | Output-enable product term |
| cfg | input | 4 | {reg_sel, invert, fb_code[1:0]} |
| pin_in | input | 1 | Level driven onto the pin from outside while released |
| pin_out | output | 1 | Data driven to the pin |
| pin_oe | output | 1 | Pin driver enable |
| fb_out | output | 1 | Feedback into the array |

## Verification
Preset and clear can both be active in the same cycle. So can an asynchronous clear and a register load. The sweep drives every combination of preset_term and clear_term, in several different orders, under every configuration code. clear_term is raised half a cycle before the clock edge, so the forced-low Q is checked before the edge and again after it. The preset-only and both-active cases are judged from the Q seen through feedback code 0 and through the registered pin.

// File: rtl/ocell_pkg.sv
package ocell_pkg;

    typedef enum logic [1:0] {
        FB_REG     = 2'd0,
        FB_SUM     = 2'd1,
        FB_PIN     = 2'd2,
        FB_PIN_ALT = 2'd3
    } fb_src_e;

    typedef struct packed {
        logic    reg_sel;
        logic    invert;
        fb_src_e fb;
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);

endpackage

// File: rtl/ocell_dff.sv
module ocell_dff #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    input  logic set_sync,
    input  logic clr_async,
    output logic q
);
    typedef struct packed {
        logic q;
    } dff_state_t;

    dff_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_sync) begin
            st_d.q = 1'b1;
        end else begin
            st_d.q = d_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n or posedge clr_async) begin
        if (!rst_n) begin
            st_q.q <= RESET_VAL;
        end else if (clr_async) begin
            st_q.q <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.q;

    // R1: plain load
    a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_sync && !clr_async) |=> (clr_async || q == $past(d_in)));

    // R3: synchronous preset
    a_r3_preset: assert property (@(posedge clk) disable iff (!rst_n)
        (set_sync && !clr_async) |=> (clr_async || q));

    // R4: clear already holds Q low when sampled
    a_r4_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
        clr_async |-> !q);

    // R5: clear dominates preset
    a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_async && set_sync) |=> (!q || !clr_async || $past(!clr_async)));

endmodule

// File: rtl/ocell_outpath.sv
module ocell_outpath (
    input  logic sum_in,
    input  logic q,
    input  logic reg_sel,
    input  logic invert,
    input  logic oe_term,
    output logic pin_out,
    output logic pin_oe
);
    logic core_d;
    logic polar_d;

    always_comb begin
        core_d  = reg_sel ? q : sum_in;
        polar_d = core_d ^ invert;
        pin_oe  = oe_term;
        pin_out = oe_term ? polar_d : 1'b0;
    end
endmodule

// File: rtl/ocell_fbmux.sv
module ocell_fbmux (
    input  logic                clk,
    input  logic                rst_n,
    input  ocell_pkg::fb_src_e  fb_code,
    input  logic                q,
    input  logic                sum_in,
    input  logic                pin_out,
    input  logic                pin_oe,
    input  logic                pin_in,
    output logic                fb_out
);
    import ocell_pkg::*;

    logic pin_level_d;

    always_comb begin
        pin_level_d = pin_oe ? pin_out : pin_in;
        unique case (fb_code)
            FB_REG:  fb_out = q;
            FB_SUM:  fb_out = sum_in;
            default: fb_out = pin_level_d;
        endcase
    end

    // R10: released pin feeds the external level back
    a_r10_pin_feedback: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_code[1] && !pin_oe) |-> (fb_out == pin_in));

    // R8: register feedback is the true Q
    a_r8_reg_feedback: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_code == FB_REG) |-> (fb_out == q));

endmodule

// File: rtl/logic_out_cell.sv
module logic_out_cell (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sum_in,
    input  logic                        preset_term,
    input  logic                        clear_term,
    input  logic                        oe_term,
    input  logic [ocell_pkg::CFG_W-1:0] cfg,
    input  logic                        pin_in,
    output logic                        pin_out,
    output logic                        pin_oe,
    output logic                        fb_out
);
    import ocell_pkg::*;

    cell_cfg_t cfg_s;
    logic      q;

    assign cfg_s = cell_cfg_t'(cfg);

    ocell_dff #(.RESET_VAL(1'b0)) u_dff (
        .clk       (clk),
        .rst_n     (rst_n),
        .d_in      (sum_in),
        .set_sync  (preset_term),
        .clr_async (clear_term),
        .q         (q)
    );

    ocell_outpath u_out (
        .sum_in  (sum_in),
        .q       (q),
        .reg_sel (cfg_s.reg_sel),
        .invert  (cfg_s.invert),
        .oe_term (oe_term),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    ocell_fbmux u_fb (
        .clk     (clk),
        .rst_n   (rst_n),
        .fb_code (cfg_s.fb),
        .q       (q),
        .sum_in  (sum_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .pin_in  (pin_in),
        .fb_out  (fb_out)
    );

    // R7: released driver carries no data
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> !pin_out);

    // R7: enable follows its term
    a_r7_enable: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe == oe_term);

    // R2: combinatorial, active-high, enabled pin equals sum
    a_r2_comb_path: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_s.reg_sel && !cfg_s.invert && oe_term) |-> (pin_out == sum_in));

endmodule

// File: tb/logic_out_cell_tb.sv
module logic_out_cell_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sum_in = 1'b0, preset_term = 1'b0, clear_term = 1'b0;
    logic       oe_term = 1'b0, pin_in = 1'b0;
    logic [3:0] cfg = 4'd0;
    logic       pin_out, pin_oe, fb_out;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 0;
    logic mq = 1'b0;

    always #5 clk = ~clk;

    logic_out_cell dut_i (
        .clk(clk), .rst_n(rst_n), .sum_in(sum_in), .preset_term(preset_term),
        .clear_term(clear_term), .oe_term(oe_term), .cfg(cfg), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cfg=%0d actual=%b expected=%b t=%0t", req, cfg, act, exp, $time);
        end
    endtask

    task automatic check_all(input string phase);
        logic data, pexp, fexp;
        string tp, tf;
        data = cfg[3] ? mq : sum_in;                  // R1 / R2
        pexp = oe_term ? (data ^ cfg[2]) : 1'b0;      // R6 / R7
        case (cfg[1:0])
            2'd0:    begin fexp = mq;     tf = "R8";  end
            2'd1:    begin fexp = sum_in; tf = "R9";  end
            default: begin fexp = oe_term ? pexp : pin_in; tf = "R10"; end
        endcase
        tp = !oe_term ? "R7" : (cfg[3] ? "R1 R6" : "R2 R6");
        if (clear_term && preset_term) tf = {tf, " R5"};
        else if (clear_term)           tf = {tf, " R4"};
        else if (preset_term && phase == "post") tf = {tf, " R3"};
        check({tp, " pin_out ", phase}, pin_out, pexp);
        check({"R7 pin_oe ", phase}, pin_oe, oe_term);
        check({tf, " fb_out ", phase}, fb_out, fexp);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R11: reset holds Q low, observed through register feedback
        sum_in = 1'b1; preset_term = 1'b1; cfg = 4'b1000; oe_term = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R11 fb_out in reset", fb_out, 1'b0);
        check("R11 R1 pin_out in reset", pin_out, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        preset_term = 1'b0; sum_in = 1'b0;
        mq = 1'b0;

        for (int rep = 0; rep < 2; rep++) begin
            for (int c = 0; c < 16; c++) begin
                for (int k = 0; k < 64; k++) begin
                    int v;
                    v = (k * (rep ? 13 : 7) + c * 3) % 32;
                    @(negedge clk);
                    cfg         = 4'(c);
                    sum_in      = v[0];
                    oe_term     = v[1];
                    pin_in      = v[2];
                    preset_term = v[3];
                    clear_term  = v[4];
                    #1;
                    if (clear_term) mq = 1'b0;   // R4: no clock needed
                    check_all("pre");
                    @(posedge clk);
                    if (clear_term)       mq = 1'b0;   // R4 R5
                    else if (preset_term) mq = 1'b1;   // R3
                    else                  mq = sum_in; // R1
                    #2;
                    check_all("post");
                end
            end
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule